// File: doc/BRIEF.md
# Vehicle Bus Transceiver Mode and Wake Controller

This block is the digital control core of a single-wire vehicle bus transceiver. It takes a standby control line, a two-bit pre-decoded mode code (low, high or floating pin), transmit data, and the digitized output of the bus-active comparator. It also takes a local wake input, an over-temperature flag and an active-low power-on reset. From these it drives the bus transmitter enable, a waveshaping enable, the receive data line to the link controller, and a supply enable. The supply enable switches an external voltage regulator.

While the standby line is high, the mode code selects one of three modes. Normal mode drives with waveshaping. Fast mode drives with waveshaping off. Loop-back returns transmit data to the receive line and keeps the bus driver off. When the standby line is low, the transmitter is off and the receive line shows bus activity, so that a wake-up can be seen. A falling edge on the standby line starts a timed countdown. At the end of the countdown the supply enable is released and the block sleeps. Bus activity, an edge on the local wake line, or a high standby line turns the supply back on. An over-temperature event latches the driver off. The latch clears only on a rising transmit edge that comes after the flag has dropped. Every interface is a plain level signal. No stream or handshake is involved, so no back-pressure applies.

Top module: `vbus_xcvr_ctrl`

## Requirements
- R1: After power-on reset, supply_en is 1, drv_en is 0 and the block is in low-power standby.
- R2: With standby high and mode code 00 (normal), drv_en equals the synchronized tx_data, shape_en is 1, and rx_out is the inverse of the synchronized bus_active.
- R3: With standby high and mode code 01 (fast), drv_en equals the synchronized tx_data and shape_en is 0.
- R4: With standby high and mode code 10 (floating) or 11 (illegal), the block is in loop-back: drv_en is 0 and rx_out is the inverse of the synchronized tx_data.
- R5: With standby low, rx_out is the inverse of the synchronized bus_active, whether the supply is on or off.
- R6: With standby low, drv_en is 0 regardless of tx_data.
- R7: After a falling edge on stby_ctl, if stby_ctl stays low, supply_en goes to 0 after the (SLEEP_CYCLES+3)th rising clock edge. The first edge that samples the low level counts as edge 1.
- R8: If stby_ctl returns high before the countdown ends, supply_en stays 1.
- R9: In sleep, a high synchronized bus_active sets supply_en back to 1.
- R10: In sleep, a rising or a falling edge on lwake sets supply_en back to 1.
- R11: In sleep, a high level on stby_ctl sets supply_en back to 1.
- R12: When standby is low without a preceding falling edge, for example after reset, supply_en stays 1 indefinitely.
- R13: A high overtemp forces drv_en to 0 from the next cycle onward. The latch holds after overtemp drops, and it clears only on the first rising edge of synchronized tx_data that is seen while overtemp is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| stby_ctl | input | 1 | Standby control; high enables transmit modes |
| mode_code | input | 2 | Mode pin code: 00 low, 01 high, 10 float, 11 illegal |
| tx_data | input | 1 | Transmit data from the link controller |
| bus_active | input | 1 | Bus comparator output, high when the bus is active |
| lwake | input | 1 | Local wake input, both edges significant |
| overtemp | input | 1 | Die over-temperature flag |
| drv_en | output | 1 | Bus transmitter enable |
| shape_en | output | 1 | Output waveshaping enable |
| rx_out | output | 1 | Receive data, low when activity is seen |
| supply_en | output | 1 | External regulator enable |

## Verification
The transmit path is tried with alternating and held tx_data patterns under each of the four mode codes. These patterns tell normal, fast and loop-back apart through drv_en, shape_en and rx_out, and they show that code 11 never drives the bus. The bus comparator is toggled in active modes, in standby and in sleep, to separate receive passthrough from the loop-back return. The sleep sequence is run to completion with an exact edge count. It is also aborted part-way, and it is ended by each of the three wake sources, with lwake tried on both edge polarities. A thermal pulse with tx_data held high checks that the latch does not clear on a level. A pulse followed by a fresh rising edge checks the release.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam logic [1:0] MC_LOW   = 2'b00;
  localparam logic [1:0] MC_HIGH  = 2'b01;
  localparam logic [1:0] MC_FLOAT = 2'b10;

  typedef enum logic [1:0] {
    OP_LOWPWR,
    OP_NORMAL,
    OP_FAST,
    OP_LOOP
  } op_mode_e;

  typedef enum logic [1:0] {
    PS_STBY,
    PS_ACTIVE,
    PS_COUNT,
    PS_SLEEP
  } pwr_state_e;

endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) stg[g] <= '0;
      else        stg[g] <= stg[g-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/xcvr_mode_dec.sv
module xcvr_mode_dec
  import xcvr_pkg::*;
(
  input  logic       stby_s,
  input  logic [1:0] mode_code,
  input  logic       tx_s,
  input  logic       bus_s,
  input  logic       therm_off,
  output op_mode_e   op_mode,
  output logic       drv_en,
  output logic       shape_en,
  output logic       rx_out
);

  always_comb begin
    if (!stby_s) begin
      op_mode = OP_LOWPWR;
    end else begin
      unique case (mode_code)
        MC_LOW:  op_mode = OP_NORMAL;
        MC_HIGH: op_mode = OP_FAST;
        default: op_mode = OP_LOOP;   // float and illegal code both isolate the bus
      endcase
    end
  end

  always_comb begin
    drv_en   = 1'b0;
    shape_en = 1'b1;
    rx_out   = ~bus_s;
    unique case (op_mode)
      OP_NORMAL: drv_en = tx_s & ~therm_off;
      OP_FAST: begin
        drv_en   = tx_s & ~therm_off;
        shape_en = 1'b0;
      end
      OP_LOOP:   rx_out = ~tx_s;
      default: ;
    endcase
  end

endmodule

// File: rtl/xcvr_pwr_seq.sv
module xcvr_pwr_seq
  import xcvr_pkg::*;
#(
  parameter int SLEEP_CYCLES = 16000
) (
  input  logic clk,
  input  logic por_n,
  input  logic stby_s,
  input  logic bus_s,
  input  logic lwake_s,
  output logic supply_en
);

  localparam int CW = $clog2(SLEEP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SLEEP_CYCLES - 1);

  pwr_state_e      state, state_nx;
  logic [CW-1:0]   cnt, cnt_nx;
  logic            lwake_d;
  logic            wake;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) lwake_d <= 1'b0;
    else        lwake_d <= lwake_s;
  end

  assign wake = bus_s | (lwake_s ^ lwake_d) | stby_s;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    if (stby_s) begin
      state_nx = PS_ACTIVE;
      cnt_nx   = '0;
    end else begin
      unique case (state)
        PS_ACTIVE: begin
          state_nx = PS_COUNT;   // falling edge of standby: start timeout
          cnt_nx   = '0;
        end
        PS_COUNT: begin
          if (cnt == LAST) state_nx = PS_SLEEP;
          else             cnt_nx   = cnt + 1'b1;
        end
        PS_SLEEP: if (wake) state_nx = PS_STBY;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state <= PS_STBY;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  assign supply_en = (state != PS_SLEEP);

endmodule

// File: rtl/xcvr_therm_latch.sv
module xcvr_therm_latch (
  input  logic clk,
  input  logic por_n,
  input  logic overtemp,
  input  logic tx_s,
  output logic therm_off
);

  logic tx_d;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      tx_d      <= 1'b0;
      therm_off <= 1'b0;
    end else begin
      tx_d <= tx_s;
      if (overtemp)            therm_off <= 1'b1;
      else if (tx_s && !tx_d)  therm_off <= 1'b0;
    end
  end

endmodule

// File: rtl/vbus_xcvr_ctrl.sv
module vbus_xcvr_ctrl
  import xcvr_pkg::*;
#(
  parameter int SLEEP_CYCLES = 16000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       stby_ctl,
  input  logic [1:0] mode_code,
  input  logic       tx_data,
  input  logic       bus_active,
  input  logic       lwake,
  input  logic       overtemp,
  output logic       drv_en,
  output logic       shape_en,
  output logic       rx_out,
  output logic       supply_en
);

  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, syn;
  logic             stby_s, tx_s, bus_s, lwake_s;
  logic             therm_off;
  op_mode_e         op_mode;

  assign raw_in = {lwake, bus_active, tx_data, stby_ctl};
  assign {lwake_s, bus_s, tx_s, stby_s} = syn;

  xcvr_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_n(por_n), .din(raw_in), .dout(syn)
  );

  xcvr_therm_latch u_therm (
    .clk(clk), .por_n(por_n), .overtemp(overtemp), .tx_s(tx_s),
    .therm_off(therm_off)
  );

  xcvr_pwr_seq #(.SLEEP_CYCLES(SLEEP_CYCLES)) u_pwr (
    .clk(clk), .por_n(por_n), .stby_s(stby_s), .bus_s(bus_s),
    .lwake_s(lwake_s), .supply_en(supply_en)
  );

  xcvr_mode_dec u_dec (
    .stby_s(stby_s), .mode_code(mode_code), .tx_s(tx_s), .bus_s(bus_s),
    .therm_off(therm_off), .op_mode(op_mode), .drv_en(drv_en),
    .shape_en(shape_en), .rx_out(rx_out)
  );

endmodule

// File: rtl/xcvr_ctrl_chk.sv
module xcvr_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       stby_ctl,
  input logic [1:0] mode_code,
  input logic       tx_data,
  input logic       overtemp,
  input logic       drv_en,
  input logic       shape_en,
  input logic       supply_en
);

  // R4: mode code 10/11 never enables the driver
  assert_loop_quiet_R4: assert property (@(posedge clk) disable iff (!por_n)
    mode_code[1] |-> !drv_en);

  // R3: waveshaping only switched off in fast mode
  assert_fast_unshaped_R3: assert property (@(posedge clk) disable iff (!por_n)
    !shape_en |-> (mode_code == 2'b01));

  // R2: driver activity traces back to transmit data two edges earlier
  assert_drv_from_tx_R2: assert property (@(posedge clk) disable iff (!por_n)
    drv_en |-> $past(tx_data, 2));

  // R13: overtemp blocks the driver from the next cycle
  assert_therm_block_R13: assert property (@(posedge clk) disable iff (!por_n)
    overtemp |=> !drv_en);

  // R7: supply released only after standby has been held low
  assert_sleep_needs_low_R7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(supply_en) |-> (!$past(stby_ctl) && !$past(stby_ctl, 2)));

endmodule

bind vbus_xcvr_ctrl xcvr_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .stby_ctl(stby_ctl), .mode_code(mode_code),
  .tx_data(tx_data), .overtemp(overtemp), .drv_en(drv_en),
  .shape_en(shape_en), .supply_en(supply_en)
);

// File: tb/vbus_xcvr_ctrl_test.sv
module vbus_xcvr_ctrl_test;

  localparam int LIM = 24;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       stby_ctl = 1'b0;
  logic [1:0] mode_code = 2'b10;
  logic       tx_data = 1'b0;
  logic       bus_active = 1'b0;
  logic       lwake = 1'b0;
  logic       overtemp = 1'b0;
  logic       drv_en, shape_en, rx_out, supply_en;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vbus_xcvr_ctrl #(.SLEEP_CYCLES(LIM)) uut (
    .clk(clk), .por_n(por_n), .stby_ctl(stby_ctl), .mode_code(mode_code),
    .tx_data(tx_data), .bus_active(bus_active), .lwake(lwake),
    .overtemp(overtemp), .drv_en(drv_en), .shape_en(shape_en),
    .rx_out(rx_out), .supply_en(supply_en)
  );

  // ---------------- behavioural reference model ----------------
  bit st_q[$], tx_q[$], bus_q[$], lw_q[$];
  bit m_lw_prev, m_tx_prev, m_hot;
  int m_phase;   // 0 awake-low, 1 awake-high, 2 counting, 3 asleep
  int m_count;

  function automatic void model_reset();
    st_q = '{0, 0}; tx_q = '{0, 0}; bus_q = '{0, 0}; lw_q = '{0, 0};
    m_lw_prev = 0; m_tx_prev = 0; m_hot = 0; m_phase = 0; m_count = 0;
  endfunction

  initial model_reset();

  task automatic cmp(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit s_st, s_tx, s_bus, s_lw, wk;
    bit e_drv, e_shape, e_rx, e_sup;
    if (!por_n) begin
      model_reset();
    end else begin
      s_st = st_q[0]; s_tx = tx_q[0]; s_bus = bus_q[0]; s_lw = lw_q[0];
      wk = s_bus || (s_lw != m_lw_prev) || s_st;
      if (s_st) begin m_phase = 1; m_count = 0; end
      else if (m_phase == 1) begin m_phase = 2; m_count = 0; end
      else if (m_phase == 2) begin
        if (m_count == LIM - 1) m_phase = 3; else m_count++;
      end else if (m_phase == 3 && wk) m_phase = 0;
      if (overtemp) m_hot = 1;
      else if (s_tx && !m_tx_prev) m_hot = 0;
      m_lw_prev = s_lw; m_tx_prev = s_tx;
      void'(st_q.pop_front());  st_q.push_back(stby_ctl);
      void'(tx_q.pop_front());  tx_q.push_back(tx_data);
      void'(bus_q.pop_front()); bus_q.push_back(bus_active);
      void'(lw_q.pop_front());  lw_q.push_back(lwake);
    end
    #1;
    if (!done) begin
      e_sup = (m_phase != 3);
      e_shape = 1; e_drv = 0; e_rx = !bus_q[0];
      if (st_q[0]) begin
        if (mode_code == 2'b00) e_drv = tx_q[0] && !m_hot;
        else if (mode_code == 2'b01) begin e_drv = tx_q[0] && !m_hot; e_shape = 0; end
        else e_rx = !tx_q[0];
      end
      cmp(cur_req, "drv_en", drv_en, e_drv);
      cmp(cur_req, "shape_en", shape_en, e_shape);
      cmp(cur_req, "rx_out", rx_out, e_rx);
      cmp(cur_req, "supply_en", supply_en, e_sup);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_sleep();
    stby_ctl = 1'b1; cyc(4);
    stby_ctl = 1'b0; cyc(LIM + 6);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (R1..) actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int edges;
    cyc(4);
    por_n = 1'b1;
    cyc(1);
    // R1: reset state
    cmp("R1", "supply_en", supply_en, 1'b1);
    cmp("R1", "drv_en", drv_en, 1'b0);

    // R12: low standby without a falling edge never times out
    cur_req = "R12"; cyc(3 * LIM);
    cmp("R12", "supply_en", supply_en, 1'b1);

    // R5/R6: standby, bus toggles visible, tx ignored by driver
    cur_req = "R5";
    for (int i = 0; i < 6; i++) begin bus_active = i[0]; tx_data = ~i[0]; cyc(3); end
    bus_active = 1'b1; tx_data = 1'b1; cyc(3);
    cmp("R5", "rx_out", rx_out, 1'b0);
    cmp("R6", "drv_en", drv_en, 1'b0);
    bus_active = 1'b0; tx_data = 1'b0;

    // R2: normal mode
    cur_req = "R2"; mode_code = 2'b00; stby_ctl = 1'b1; cyc(3);
    for (int i = 0; i < 10; i++) begin tx_data = i[0]; bus_active = i[1]; cyc(1 + i % 3); end
    tx_data = 1'b1; cyc(3);
    cmp("R2", "drv_en", drv_en, 1'b1);
    cmp("R2", "shape_en", shape_en, 1'b1);

    // R3: fast mode
    cur_req = "R3"; mode_code = 2'b01;
    for (int i = 0; i < 10; i++) begin tx_data = ~i[0]; bus_active = i[0]; cyc(2); end
    tx_data = 1'b1; cyc(3);
    cmp("R3", "drv_en", drv_en, 1'b1);
    cmp("R3", "shape_en", shape_en, 1'b0);

    // R4: loop-back, float and illegal codes
    cur_req = "R4";
    for (int m = 2; m < 4; m++) begin
      mode_code = 2'(m);
      for (int i = 0; i < 8; i++) begin tx_data = i[0]; bus_active = i[1]; cyc(2); end
      tx_data = 1'b1; bus_active = 1'b0; cyc(3);
      cmp("R4", "drv_en", drv_en, 1'b0);
      cmp("R4", "rx_out", rx_out, 1'b0);
    end
    tx_data = 1'b0; mode_code = 2'b00; cyc(3);

    // R7: exact timeout length
    cur_req = "R7"; stby_ctl = 1'b0; edges = 0;
    for (int k = 0; k < LIM + 20; k++) begin
      @(posedge clk); #1; edges++;
      if (!supply_en) break;
    end
    cmp("R7", "timeout_edges_ok", 1'(edges == LIM + 3), 1'b1);
    if (edges != LIM + 3) $display("FAIL R7 edges actual=%0d expected=%0d", edges, LIM + 3);
    cyc(2);

    // R5 in sleep: rx still follows bus; R9 bus wake
    cur_req = "R9"; bus_active = 1'b1; cyc(4);
    cmp("R9", "supply_en", supply_en, 1'b1);
    cmp("R5", "rx_out", rx_out, 1'b0);
    bus_active = 1'b0;

    // R10: lwake rising then falling edge
    cur_req = "R10"; go_sleep();
    cmp("R10", "asleep", supply_en, 1'b0);
    lwake = 1'b1; cyc(4);
    cmp("R10", "supply_en_rise", supply_en, 1'b1);
    go_sleep();
    lwake = 1'b0; cyc(4);
    cmp("R10", "supply_en_fall", supply_en, 1'b1);

    // R11: standby high wakes
    cur_req = "R11"; go_sleep();
    stby_ctl = 1'b1; cyc(4);
    cmp("R11", "supply_en", supply_en, 1'b1);

    // R8: cancelled countdown
    cur_req = "R8"; stby_ctl = 1'b0; cyc(LIM / 2);
    stby_ctl = 1'b1; cyc(2 * LIM);
    cmp("R8", "supply_en", supply_en, 1'b1);

    // R13: thermal latch
    cur_req = "R13"; mode_code = 2'b00; tx_data = 1'b1; cyc(4);
    overtemp = 1'b1; cyc(2);
    cmp("R13", "drv_en_hot", drv_en, 1'b0);
    overtemp = 1'b0; cyc(6);
    cmp("R13", "drv_en_held", drv_en, 1'b0);
    tx_data = 1'b0; cyc(3);
    tx_data = 1'b1; cyc(5);
    cmp("R13", "drv_en_release", drv_en, 1'b1);
    stby_ctl = 1'b0; tx_data = 1'b0; cyc(4);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule